// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It has two component predictors. The global component keeps one shared shift register holding the most recent branch outcomes and uses it to index a table of 2-bit counters. The local component is two-level. A table indexed by branch address holds each branch's own recent outcome pattern, and that pattern indexes a table of 3-bit counters. A third table of 2-bit counters, indexed by branch address, acts as the arbiter. For each branch it learns which component to trust.

The fetch side presents a PC on the lookup port. The same cycle, it gets back the final direction and both component directions, read combinationally from the current table state. When the branch retires, its PC and real outcome go to the resolve port. On the next clock edge, both components train, the arbiter trains, and both histories shift in the outcome. Target prediction and the repair of speculative history lie outside this block.

Top module: `tourney_bp`

## Requirements
- R1: After reset every arbiter counter is 1 (weakly local), every 2-bit global counter is 1 (weakly not taken), every 3-bit local counter is 3, and all histories are zero. So every lookup returns not taken on all three prediction outputs.
- R2: `glob_pred_o` is bit 1 of the 2-bit global counter indexed by the global history register.
- R3: `loc_pred_o` is 1 when the 3-bit local counter indexed by the lookup branch's local history holds a value of 4 or more.
- R4: `pred_o` equals `glob_pred_o` when bit 1 of the arbiter counter at `lookup_pc_i[PC_LSB +: CH_IDX_W]` is 1, and `loc_pred_o` otherwise.
- R5: On a resolve where exactly one component predicted the real outcome, the arbiter counter steps toward that component: up when the global component was right, down when the local one was right.
- R6: On a resolve where both components agree, the arbiter counter is not changed.
- R7: Every counter saturates. The 2-bit counters stay within 0..3 and the 3-bit counters within 0..7. Each counter steps up on taken and down on not taken.
- R8: On a resolve, the global history and the branch's local history (table entry `res_pc_i[PC_LSB +: LHT_IDX_W]`) each become `{old[W-2:0], taken}`.
- R9: All table updates on a resolve use the indices formed from history values as they stood before that resolve's shift.
- R10: With `res_valid_i` low, no table, counter or history changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lookup_pc_i | input | PC_W | Address of the branch being predicted |
| pred_o | output | 1 | Final direction, 1 = taken |
| glob_pred_o | output | 1 | Global component direction |
| loc_pred_o | output | 1 | Local component direction |
| res_valid_i | input | 1 | Resolve strobe |
| res_pc_i | input | PC_W | Address of the resolving branch |
| res_taken_i | input | 1 | Real outcome of the resolving branch |

## Verification
The bench builds the predictor with 16-entry arbiter and global tables, a 4-bit global history, an 8-entry local history table and a 16-entry local counter table. PCs come from a small set, so address aliasing, history wrap-around and counter saturation at both ends happen within a few hundred resolves. These sizes also let the arbiter flip between components many times. Long runs of one outcome on one address drive the 3-bit counters to 0 and 7. Cycles with the resolve strobe low are interleaved with the rest to show that the state holds still.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  localparam int unsigned GLOB_CTR_W = 2;
  localparam int unsigned LOC_CTR_W  = 3;
  localparam int unsigned CH_CTR_W   = 2;
  localparam int unsigned GLOB_INIT  = 1;
  localparam int unsigned LOC_INIT   = 3;
  localparam int unsigned CH_INIT    = 1;

  typedef enum logic {
    PICK_LOC  = 1'b0,
    PICK_GLOB = 1'b1
  } pick_e;
endpackage

// File: rtl/tbp_sat_tbl.sv
module tbp_sat_tbl #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned CTR_W = 2,
  parameter int unsigned INIT  = 1,
  parameter int unsigned NRD   = 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NRD-1:0][IDX_W-1:0]   rd_idx_i,
  output logic [NRD-1:0][CTR_W-1:0]   rd_ctr_o,
  input  logic                        we_i,
  input  logic [IDX_W-1:0]            wr_idx_i,
  input  logic                        up_i
);
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CMAX = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] CINI = CTR_W'(INIT);

  logic [CTR_W-1:0] mem_q [DEPTH];
  logic [CTR_W-1:0] cur;

  assign cur = mem_q[wr_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= CINI;
    end else if (we_i) begin
      if (up_i && cur != CMAX)         mem_q[wr_idx_i] <= cur + 1'b1;
      else if (!up_i && cur != '0)     mem_q[wr_idx_i] <= cur - 1'b1;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_ctr_o[r] = mem_q[rd_idx_i[r]];
  end
endmodule

// File: rtl/tbp_lht.sv
module tbp_lht #(
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned HIST_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  lk_idx_i,
  output logic [HIST_W-1:0] lk_hist_o,
  input  logic [IDX_W-1:0]  rs_idx_i,
  output logic [HIST_W-1:0] rs_hist_o,
  input  logic              we_i,
  input  logic              taken_i
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] hist_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
    end else if (we_i) begin
      hist_q[rs_idx_i] <= {hist_q[rs_idx_i][HIST_W-2:0], taken_i};
    end
  end

  assign lk_hist_o = hist_q[lk_idx_i];
  assign rs_hist_o = hist_q[rs_idx_i];
endmodule

// File: rtl/tourney_bp.sv
module tourney_bp
  import tbp_pkg::*;
#(
  parameter int unsigned PC_W      = 32,
  parameter int unsigned PC_LSB    = 2,
  parameter int unsigned CH_IDX_W  = 10,
  parameter int unsigned GHIST_W   = 10,
  parameter int unsigned LHT_IDX_W = 8,
  parameter int unsigned LHIST_W   = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lookup_pc_i,
  output logic            pred_o,
  output logic            glob_pred_o,
  output logic            loc_pred_o,
  input  logic            res_valid_i,
  input  logic [PC_W-1:0] res_pc_i,
  input  logic            res_taken_i
);
  logic [GHIST_W-1:0] ghist_q;

  logic [CH_IDX_W-1:0]  lk_ch_idx, rs_ch_idx;
  logic [LHT_IDX_W-1:0] lk_lht_idx, rs_lht_idx;
  logic [LHIST_W-1:0]   lk_lhist, rs_lhist;

  logic [0:0][GLOB_CTR_W-1:0] g_ctr;
  logic [1:0][LOC_CTR_W-1:0]  l_ctr;
  logic [0:0][CH_CTR_W-1:0]   c_ctr;

  logic rs_gp, rs_lp, ch_we, unused_pc;

  assign lk_ch_idx  = lookup_pc_i[PC_LSB +: CH_IDX_W];
  assign rs_ch_idx  = res_pc_i[PC_LSB +: CH_IDX_W];
  assign lk_lht_idx = lookup_pc_i[PC_LSB +: LHT_IDX_W];
  assign rs_lht_idx = res_pc_i[PC_LSB +: LHT_IDX_W];
  assign unused_pc  = ^{lookup_pc_i, res_pc_i};

  tbp_lht #(.IDX_W(LHT_IDX_W), .HIST_W(LHIST_W)) u_lht (
    .clk_i, .rst_ni,
    .lk_idx_i (lk_lht_idx), .lk_hist_o (lk_lhist),
    .rs_idx_i (rs_lht_idx), .rs_hist_o (rs_lhist),
    .we_i     (res_valid_i), .taken_i (res_taken_i)
  );

  // global table: lookup and resolve share the same (pre-shift) index
  tbp_sat_tbl #(.IDX_W(GHIST_W), .CTR_W(GLOB_CTR_W), .INIT(GLOB_INIT), .NRD(1)) u_glob (
    .clk_i, .rst_ni,
    .rd_idx_i (ghist_q), .rd_ctr_o (g_ctr),
    .we_i     (res_valid_i), .wr_idx_i (ghist_q), .up_i (res_taken_i)
  );

  tbp_sat_tbl #(.IDX_W(LHIST_W), .CTR_W(LOC_CTR_W), .INIT(LOC_INIT), .NRD(2)) u_loc (
    .clk_i, .rst_ni,
    .rd_idx_i ({rs_lhist, lk_lhist}), .rd_ctr_o (l_ctr),
    .we_i     (res_valid_i), .wr_idx_i (rs_lhist), .up_i (res_taken_i)
  );

  assign rs_gp = g_ctr[0][GLOB_CTR_W-1];
  assign rs_lp = l_ctr[1][LOC_CTR_W-1];
  assign ch_we = res_valid_i && (rs_gp != rs_lp);

  tbp_sat_tbl #(.IDX_W(CH_IDX_W), .CTR_W(CH_CTR_W), .INIT(CH_INIT), .NRD(1)) u_ch (
    .clk_i, .rst_ni,
    .rd_idx_i (lk_ch_idx), .rd_ctr_o (c_ctr),
    .we_i     (ch_we), .wr_idx_i (rs_ch_idx), .up_i (rs_gp == res_taken_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ghist_q <= '0;
    else if (res_valid_i) ghist_q <= {ghist_q[GHIST_W-2:0], res_taken_i};
  end

  pick_e pick;
  assign pick        = pick_e'(c_ctr[0][CH_CTR_W-1]);
  assign glob_pred_o = g_ctr[0][GLOB_CTR_W-1];
  assign loc_pred_o  = l_ctr[0][LOC_CTR_W-1];
  assign pred_o      = (pick == PICK_GLOB) ? glob_pred_o : loc_pred_o;
endmodule

// File: rtl/tbp_chk.sv
module tbp_chk #(
  parameter int unsigned GHIST_W = 10
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               res_valid_i,
  input logic               res_taken_i,
  input logic [GHIST_W-1:0] ghist_i,
  input logic               pred_o,
  input logic               glob_pred_o,
  input logic               loc_pred_o
);
  assert_ghist_shift_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i |=> ghist_i == {$past(ghist_i[GHIST_W-2:0]), $past(res_taken_i)});

  assert_ghist_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i |=> $stable(ghist_i));

  assert_glob_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i |=> $stable(glob_pred_o));

  assert_agree_pick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glob_pred_o == loc_pred_o) |-> (pred_o == glob_pred_o));
endmodule

bind tourney_bp tbp_chk #(.GHIST_W(GHIST_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .res_valid_i (res_valid_i),
  .res_taken_i (res_taken_i),
  .ghist_i     (ghist_q),
  .pred_o      (pred_o),
  .glob_pred_o (glob_pred_o),
  .loc_pred_o  (loc_pred_o)
);

// File: tb/sim_tourney_bp.sv
module sim_tourney_bp;
  localparam int PC_W = 16, PC_LSB = 2, CH_W = 4, GH_W = 4, LHT_W = 3, LH_W = 4;

  logic clk = 0, rst_n = 0;
  logic [PC_W-1:0] lk_pc = '0, rs_pc = '0;
  logic rs_v = 0, rs_t = 0;
  logic pred, gpred, lpred;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int ch [1<<CH_W];
  int gt [1<<GH_W];
  int lt [1<<LH_W];
  int lht[1<<LHT_W];
  int gh;

  always #5 clk = ~clk;

  tourney_bp #(.PC_W(PC_W), .PC_LSB(PC_LSB), .CH_IDX_W(CH_W), .GHIST_W(GH_W),
               .LHT_IDX_W(LHT_W), .LHIST_W(LH_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .lookup_pc_i(lk_pc), .pred_o(pred),
    .glob_pred_o(gpred), .loc_pred_o(lpred), .res_valid_i(rs_v),
    .res_pc_i(rs_pc), .res_taken_i(rs_t));

  function automatic int ci(logic [PC_W-1:0] p); return int'(p[PC_LSB +: CH_W]); endfunction
  function automatic int li(logic [PC_W-1:0] p); return int'(p[PC_LSB +: LHT_W]); endfunction
  function automatic bit m_g(); return gt[gh] >= 2; endfunction
  function automatic bit m_l(logic [PC_W-1:0] p); return lt[lht[li(p)]] >= 4; endfunction
  function automatic bit m_p(logic [PC_W-1:0] p); return (ch[ci(p)] >= 2) ? m_g() : m_l(p); endfunction
  function automatic int sat(int v, bit up, int mx);
    if (up) return (v < mx) ? v + 1 : v;
    return (v > 0) ? v - 1 : v;
  endfunction

  task automatic chk(bit act, bit exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    foreach (ch[i])  ch[i]  = 1;
    foreach (gt[i])  gt[i]  = 1;
    foreach (lt[i])  lt[i]  = 3;
    foreach (lht[i]) lht[i] = 0;
    gh = 0;
  endtask

  // drive at negedge, compare before the edge, then advance the model (R9: pre-shift indices)
  task automatic step(logic [PC_W-1:0] lp, bit v, logic [PC_W-1:0] rp, bit t);
    int gi, lx;
    bit gp, lpp;
    @(negedge clk);
    lk_pc = lp; rs_v = v; rs_pc = rp; rs_t = t;
    #1;
    chk(gpred, m_g(), "R2 R7 R8 global");
    chk(lpred, m_l(lp), "R3 R7 R8 local");
    chk(pred, m_p(lp), "R4 R5 R6 R9 R10 final");
    if (v) begin
      gi = gh; lx = lht[li(rp)];
      gp = gt[gi] >= 2; lpp = lt[lx] >= 4;
      if (gp != lpp) ch[ci(rp)] = sat(ch[ci(rp)], gp == t, 3);
      gt[gi] = sat(gt[gi], t, 3);
      lt[lx] = sat(lt[lx], t, 7);
      lht[li(rp)] = ((lht[li(rp)] << 1) | int'(t)) & ((1 << LH_W) - 1);
      gh = ((gh << 1) | int'(t)) & ((1 << GH_W) - 1);
    end
  endtask

  function automatic logic [PC_W-1:0] rpc();
    return PC_W'(($urandom % 12) << PC_LSB);
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state reads not taken everywhere
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); lk_pc = PC_W'(k << PC_LSB); #1;
      chk(pred, 1'b0, "R1 final");
      chk(gpred, 1'b0, "R1 global");
      chk(lpred, 1'b0, "R1 local");
    end
    // R7: saturate up then down on one address
    for (int k = 0; k < 20; k++) step(16'h0010, 1, 16'h0010, 1);
    for (int k = 0; k < 20; k++) step(16'h0010, 1, 16'h0010, 0);
    // R10: strobe low with garbage outcome
    for (int k = 0; k < 20; k++) step(rpc(), 0, rpc(), 1'($urandom));
    // R5 R6: alternating pattern favours local history over global
    for (int k = 0; k < 60; k++) step(16'h0020, 1, 16'h0020, 1'(k & 1));
    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [PC_W-1:0] p = rpc();
      bit t = (p[PC_LSB] ? ($urandom % 8 != 0) : 1'($urandom));
      step(rpc(), ($urandom % 4 != 0), p, t);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule